// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block watches the two open-drain lines of an I2C bus, sampled by a fast system clock, and turns what it sees into single-cycle event pulses and a small set of status outputs. Each line first passes through a two-flop synchronizer and then through a stability filter. The filter width can be switched at run time between a narrow and a wide value. The filtered lines are compared with their previous samples to find start and stop conditions, which set and clear a bus-busy flag. The monitor counts SCL rising edges within each transfer. On the ninth edge of every frame it reports whether the acknowledge slot held ACK or NACK, and an ACK also raises a DMA request pulse.

The block also times the local SDA drive. A new transmit bit reaches the active-low drive enable only after the filtered SCL has been low for a parameterized number of cycles. Until then the previous value is held. After reset the drive takes its level from an initial-value input.

Top module: `i2c_bus_monitor`

## Requirements
- R1: `start_evt` pulses for exactly one cycle when filtered SDA falls while filtered SCL is high in both the current and the previous sample.
- R2: `stop_evt` pulses for exactly one cycle when filtered SDA rises while filtered SCL is high in both the current and the previous sample.
- R3: `bus_busy` is 0 after reset. It becomes 1 in the cycle a start is flagged and returns to 0 in the cycle a stop is flagged.
- R4: `bit_count` is 0 after reset and after a start or stop. It rises by one on each filtered SCL rising edge while `bus_busy` is 1, and returns to 0 on the FRAME_BITS-th edge (default 9). Edges seen while the bus is idle are not counted.
- R5: On the FRAME_BITS-th SCL rising edge, `ack_evt` pulses for one cycle if filtered SDA is 0, and `nack_evt` pulses if it is 1. The two never pulse together.
- R6: `dma_req` pulses in exactly the cycles where `ack_evt` pulses, and never with `nack_evt`.
- R7: A repeated start in the middle of a frame flags a start, keeps `bus_busy` at 1 and returns `bit_count` to 0.
- R8: Each filtered line accepts a new level only after the synchronized level has differed from it for N consecutive cycles. A pulse shorter than N cycles is dropped. A level set up before clock edge k appears on the filtered output after edge k+N+1. Both filtered lines are 1 after reset.
- R9: N is WIDE_N (default 5) when `wide_sel` is 1 and NARROW_N (default 2) when `wide_sel` is 0.
- R10: `sda_drive_n` does not change while filtered SCL is high. After filtered SCL falls at edge e, the drive takes `tx_bit` at edge e+SDA_DELAY+1 (default delay 3). From then on it follows `tx_bit` one cycle later for as long as SCL stays low.
- R11: While reset is held, `sda_drive_n` is loaded from `sda_init`, and every event output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_sel | input | 1 | 1 selects the wide filter width, 0 the narrow one |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| tx_bit | input | 1 | Data bit to place on SDA |
| sda_init | input | 1 | Drive level loaded during reset |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |
| start_evt | output | 1 | Start condition pulse |
| stop_evt | output | 1 | Stop condition pulse |
| bus_busy | output | 1 | Bus-busy flag |
| bit_count | output | $clog2(FRAME_BITS) | SCL rising edges seen in the current frame |
| ack_evt | output | 1 | Acknowledge-slot ACK pulse |
| nack_evt | output | 1 | Acknowledge-slot NACK pulse |
| dma_req | output | 1 | DMA request pulse on ACK |
| sda_drive_n | output | 1 | Active-low SDA drive enable (0 pulls the line low) |

## Verification
The assertions assume that reset is held for at least two cycles before the first check and that SDA_DELAY is at least 1. They also assume that SDA and SCL, once filtered, never change in the same sample. If they did, a start or stop could coincide with an SCL edge. The stimulus respects these limits. It changes only one raw line at a time and keeps every level stable for twelve cycles, well over the wide filter width. The only deliberately short pulses are the glitch sweep, which applies SDA pulses of every width from 1 to WIDE_N+1 while SCL is held high.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic ack;
    logic nack;
  } bus_evt_t;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int NARROW_N = 2,
  parameter int WIDE_N   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic wide_sel,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(WIDE_N + 1);

  logic [1:0]    sync;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] limit;

  assign limit = wide_sel ? CW'(WIDE_N - 1) : CW'(NARROW_N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= 2'b11;
      run_cnt <= '0;
      filt    <= 1'b1;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] == filt) begin
        run_cnt <= '0;
      end else if (run_cnt >= limit) begin
        filt    <= sync[1];
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R8: the filtered level only moves toward the synchronized level
  assert_filter_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> (filt == $past(sync[1])));
endmodule

// File: rtl/bus_events.sv
module bus_events
  import i2c_mon_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_f,
  input  logic             sda_f,
  output bus_evt_t         evt,
  output logic             dma_req,
  output logic             busy,
  output logic [CNT_W-1:0] bit_cnt
);
  logic prev_scl, prev_sda;
  logic is_start, is_stop, scl_rise;

  assign is_start = prev_scl & scl_f & prev_sda & ~sda_f;
  assign is_stop  = prev_scl & scl_f & ~prev_sda & sda_f;
  assign scl_rise = ~prev_scl & scl_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_scl <= 1'b1;
      prev_sda <= 1'b1;
      evt      <= '0;
      dma_req  <= 1'b0;
      busy     <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      prev_scl <= scl_f;
      prev_sda <= sda_f;
      evt      <= '0;
      dma_req  <= 1'b0;
      if (is_start) begin
        evt.start <= 1'b1;
        busy      <= 1'b1;
        bit_cnt   <= '0;
      end else if (is_stop) begin
        evt.stop <= 1'b1;
        busy     <= 1'b0;
        bit_cnt  <= '0;
      end else if (scl_rise && busy) begin
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          bit_cnt  <= '0;
          evt.ack  <= ~sda_f;
          evt.nack <= sda_f;
          dma_req  <= ~sda_f;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_start_single_R1: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> !evt.start);
  assert_stop_single_R2: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> !evt.stop);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    evt.start |-> busy);
  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (rst)
    evt.stop |-> !busy);
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_BITS - 1));
  assert_ack_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (evt.ack || evt.nack) |-> (bit_cnt == '0 && $past(bit_cnt) == CNT_W'(FRAME_BITS - 1)));
  assert_ack_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(evt.ack && evt.nack));
  assert_dma_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (evt.ack && !evt.nack));
endmodule

// File: rtl/sda_delay.sv
module sda_delay #(
  parameter int SDA_DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic tx_bit,
  input  logic init_lvl,
  output logic drive_n
);
  localparam int LW = $clog2(SDA_DELAY + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_n <= init_lvl;
      low_cnt <= '0;
    end else if (scl_f) begin
      low_cnt <= '0;
    end else if (low_cnt != LW'(SDA_DELAY)) begin
      low_cnt <= low_cnt + 1'b1;
    end else begin
      drive_n <= tx_bit;
    end
  end

  // R10: a drive change needs SCL low in the sample before it
  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(drive_n)) |-> !$past(scl_f));
  // R10: the edge right after SCL falls never moves the drive
  assert_drive_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_f) |=> $stable(drive_n));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int NARROW_N   = 2,
  parameter int WIDE_N     = 5,
  parameter int FRAME_BITS = 9,
  parameter int SDA_DELAY  = 3,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_sel,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             tx_bit,
  input  logic             sda_init,
  output logic             scl_filt,
  output logic             sda_filt,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             bus_busy,
  output logic [CNT_W-1:0] bit_count,
  output logic             ack_evt,
  output logic             nack_evt,
  output logic             dma_req,
  output logic             sda_drive_n
);
  logic [NUM_LINES-1:0] raw_v;
  logic [NUM_LINES-1:0] filt_v;
  bus_evt_t             evt;

  assign raw_v[LINE_SCL] = scl_in;
  assign raw_v[LINE_SDA] = sda_in;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_filter #(.NARROW_N(NARROW_N), .WIDE_N(WIDE_N)) u_filt (
      .clk(clk), .rst(rst), .wide_sel(wide_sel),
      .raw(raw_v[g]), .filt(filt_v[g])
    );
  end

  assign scl_filt = filt_v[LINE_SCL];
  assign sda_filt = filt_v[LINE_SDA];

  bus_events #(.FRAME_BITS(FRAME_BITS)) u_events (
    .clk(clk), .rst(rst), .scl_f(scl_filt), .sda_f(sda_filt),
    .evt(evt), .dma_req(dma_req), .busy(bus_busy), .bit_cnt(bit_count)
  );

  assign start_evt = evt.start;
  assign stop_evt  = evt.stop;
  assign ack_evt   = evt.ack;
  assign nack_evt  = evt.nack;

  sda_delay #(.SDA_DELAY(SDA_DELAY)) u_drive (
    .clk(clk), .rst(rst), .scl_f(scl_filt), .tx_bit(tx_bit),
    .init_lvl(sda_init), .drive_n(sda_drive_n)
  );

  // R11: no event is reported straight out of reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> !(start_evt || stop_evt || ack_evt || nack_evt || dma_req));
endmodule

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;
  localparam int NARROW_N = 2;
  localparam int WIDE_N   = 5;
  localparam int FRAME    = 9;
  localparam int DLY      = 3;
  localparam int HOLD     = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_sel = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1, tx_bit = 1'b1, sda_init = 1'b1;
  logic scl_filt, sda_filt, start_evt, stop_evt, bus_busy;
  logic [3:0] bit_count;
  logic ack_evt, nack_evt, dma_req, sda_drive_n;

  int total = 0, bad = 0;
  int n_start = 0, n_stop = 0, n_ack = 0, n_nack = 0, n_dma = 0, n_dma_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_bus_monitor #(.NARROW_N(NARROW_N), .WIDE_N(WIDE_N), .FRAME_BITS(FRAME),
                    .SDA_DELAY(DLY)) u_i2c_bus_monitor (
    .clk(clk), .rst(rst), .wide_sel(wide_sel), .scl_in(scl_in), .sda_in(sda_in),
    .tx_bit(tx_bit), .sda_init(sda_init), .scl_filt(scl_filt), .sda_filt(sda_filt),
    .start_evt(start_evt), .stop_evt(stop_evt), .bus_busy(bus_busy),
    .bit_count(bit_count), .ack_evt(ack_evt), .nack_evt(nack_evt),
    .dma_req(dma_req), .sda_drive_n(sda_drive_n)
  );

  always @(negedge clk) begin
    if (start_evt) n_start++;
    if (stop_evt)  n_stop++;
    if (ack_evt)   n_ack++;
    if (nack_evt)  n_nack++;
    if (dma_req)   n_dma++;
    if (dma_req != ack_evt) n_dma_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cond();
    sda_in = 1'b1; wait_n(HOLD);
    scl_in = 1'b1; wait_n(HOLD);
    sda_in = 1'b0; wait_n(HOLD);
    scl_in = 1'b0; wait_n(HOLD);
  endtask

  task automatic send_bit(input logic b);
    sda_in = b;    wait_n(HOLD);
    scl_in = 1'b1; wait_n(HOLD);
    scl_in = 1'b0; wait_n(HOLD);
  endtask

  task automatic stop_cond();
    sda_in = 1'b0; wait_n(HOLD);
    scl_in = 1'b1; wait_n(HOLD);
    sda_in = 1'b1; wait_n(HOLD);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int s0, p0, a0, k0, d0;
    logic [7:0] data;
    logic old_drv;

    // R11 reset state with sda_init = 1
    @(negedge clk);
    wait_n(3);
    chk(sda_drive_n == 1'b1, "R11 init level", sda_drive_n, 1);
    chk(!(start_evt | stop_evt | ack_evt | nack_evt | dma_req), "R11 quiet", 1, 0);
    rst = 1'b0;
    wait_n(2);
    chk(bus_busy == 1'b0, "R3 reset busy", bus_busy, 0);
    chk(bit_count == 0, "R4 reset count", bit_count, 0);
    chk(scl_filt && sda_filt, "R8 reset filt", {scl_filt, sda_filt}, 3);

    // R8 latency of the filter on SCL, wide mode
    scl_in = 1'b0;
    wait_n(WIDE_N + 1);
    chk(scl_filt == 1'b1, "R8 latency early", scl_filt, 1);
    wait_n(1);
    chk(scl_filt == 1'b0, "R8 latency edge", scl_filt, 0);
    scl_in = 1'b1; wait_n(HOLD);

    // R4 idle SCL clocks are not counted
    scl_in = 1'b0; wait_n(HOLD);
    scl_in = 1'b1; wait_n(HOLD);
    chk(bit_count == 0, "R4 idle clocks", bit_count, 0);

    // R8 R9 glitch sweep on SDA with SCL high, both widths
    for (int m = 0; m < 2; m++) begin
      wide_sel = (m == 0);
      wait_n(2);
      for (int w = 1; w <= WIDE_N + 1; w++) begin
        int n_mode, exp_d;
        n_mode = (m == 0) ? WIDE_N : NARROW_N;
        exp_d = (w >= n_mode) ? 1 : 0;
        s0 = n_start; p0 = n_stop;
        sda_in = 1'b0; wait_n(w);
        sda_in = 1'b1; wait_n(HOLD);
        chk(n_start - s0 == exp_d, (m == 0) ? "R9 wide glitch start" : "R9 narrow glitch start",
            n_start - s0, exp_d);
        chk(n_stop - p0 == exp_d, "R8 glitch stop", n_stop - p0, exp_d);
        chk(bus_busy == 1'b0, "R3 busy after glitch", bus_busy, 0);
      end
    end
    wide_sel = 1'b1; wait_n(2);

    // R1 R2 R3 R4 R5 R6 frame sweep
    for (int v = 0; v < 16; v++) begin
      for (int ab = 0; ab < 2; ab++) begin
        data = 8'(v * 17) ^ 8'h5A;
        s0 = n_start; p0 = n_stop; a0 = n_ack; k0 = n_nack; d0 = n_dma;
        start_cond();
        chk(n_start - s0 == 1, "R1 start", n_start - s0, 1);
        chk(bus_busy == 1'b1, "R3 busy set", bus_busy, 1);
        chk(bit_count == 0, "R4 count at start", bit_count, 0);
        for (int i = 0; i < 8; i++) begin
          send_bit(data[7 - i]);
          chk(bit_count == i + 1, "R4 count", bit_count, i + 1);
        end
        send_bit(ab[0]);
        chk(bit_count == 0, "R4 wrap", bit_count, 0);
        chk(n_ack - a0 == 1 - ab, "R5 ack", n_ack - a0, 1 - ab);
        chk(n_nack - k0 == ab, "R5 nack", n_nack - k0, ab);
        chk(n_dma - d0 == 1 - ab, "R6 dma", n_dma - d0, 1 - ab);
        stop_cond();
        chk(n_stop - p0 == 1, "R2 stop", n_stop - p0, 1);
        chk(bus_busy == 1'b0, "R3 busy clear", bus_busy, 0);
      end
    end
    chk(n_dma_bad == 0, "R6 dma alignment", n_dma_bad, 0);

    // R7 repeated start in mid frame
    start_cond();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    chk(bit_count == 4, "R7 count before", bit_count, 4);
    s0 = n_start; p0 = n_stop;
    start_cond();
    chk(n_start - s0 == 1, "R7 restart flagged", n_start - s0, 1);
    chk(n_stop - p0 == 0, "R7 no stop", n_stop - p0, 0);
    chk(bus_busy == 1'b1, "R7 busy kept", bus_busy, 1);
    chk(bit_count == 0, "R7 count cleared", bit_count, 0);
    a0 = n_ack;
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    chk(n_ack - a0 == 1, "R7 ack after restart", n_ack - a0, 1);
    stop_cond();

    // R10 drive timing
    old_drv = sda_drive_n;
    tx_bit = ~old_drv;
    wait_n(HOLD);
    chk(sda_drive_n == old_drv, "R10 hold while high", sda_drive_n, old_drv);
    scl_in = 1'b0;
    for (int g = 0; g < 40 && scl_filt; g++) wait_n(1);
    for (int j = 0; j <= DLY; j++) begin
      chk(sda_drive_n == old_drv, "R10 delay hold", sda_drive_n, old_drv);
      wait_n(1);
    end
    chk(sda_drive_n == ~old_drv, "R10 delayed update", sda_drive_n, ~old_drv);
    tx_bit = old_drv; wait_n(1);
    chk(sda_drive_n == old_drv, "R10 follow while low", sda_drive_n, old_drv);
    scl_in = 1'b1; wait_n(HOLD);
    tx_bit = ~old_drv; wait_n(HOLD);
    chk(sda_drive_n == old_drv, "R10 hold after rise", sda_drive_n, old_drv);

    // R11 reset with sda_init = 0
    sda_init = 1'b0; rst = 1'b1;
    wait_n(3);
    chk(sda_drive_n == 1'b0, "R11 init zero", sda_drive_n, 0);
    rst = 1'b0; wait_n(2);
    chk(bus_busy == 1'b0 && bit_count == 0, "R11 state after reset", bus_busy, 0);

    summary();
  end
endmodule